// File: doc/BRIEF.md
# Accumulator ALU with Legacy Flag File

This block is the arithmetic and logic unit of an 8-bit accumulator machine. The datapath is combinational. It takes the accumulator, a second operand, the current carry and half-carry flags, and a 5-bit operation code. In the same cycle it returns the result byte, the next value of each of the five status flags, and a write-enable mask. The mask says which flags the operation actually changes.

A small flag file holds the five flags. At a clock edge it loads each enabled flag, but only when the flag strobe is high. The asynchronous reset clears the whole file.

The half-carry follows the legacy rules rather than the carry out of bit 3. For add and subtract it is a three-bit lookup on bit 3 of the accumulator, bit 3 of the operand and bit 3 of the raw result. AND, increment and decrement each have their own half-carry rule.

Top module: `alu8_flags`

## Requirements
- R1: Op 0 (add) and op 1 (add with carry) form acc + opnd (+ cy_i for op 1) in 9 bits. res_o takes the low byte and cy_o takes bit 8. All five flags are written.
- R2: For add (ops 0, 1, 17), idx = {acc[3], operand[3], raw[3]}. ac_o is 1 exactly when idx is 2, 4, 6 or 7.
- R3: Op 2 (subtract) and op 3 (subtract with borrow) form acc - opnd (- cy_i for op 3). res_o is the low byte, and cy_o is 1 when the difference is negative. All five flags are written.
- R4: For ops 2, 3 and 4, ac_o is 0 exactly when the same three-bit idx is 1, 2, 3 or 7, and 1 otherwise.
- R5: Op 4 (compare) produces every flag exactly as op 2 would, writes all five, and returns res_o equal to acc_i.
- R6: Wherever sign, zero and parity are written, s_o is bit 7 of the byte those flags are taken from. z_o is 1 when that byte is 0x00, and p_o is 1 when it has an even count of ones. For op 4 that byte is the difference; for every other op it is res_o.
- R7: Op 5 (AND) gives ac_o = acc[3] | opnd[3] and cy_o = 0. Op 6 (OR) and op 7 (XOR) give ac_o = 0 and cy_o = 0. All three write all five flags.
- R8: Op 8 (increment) and op 9 (decrement) change acc by one. ac_o is 1 when the new low nibble is 0x0 for op 8, or when it is not 0xF for op 9. Both write S, Z, AC and P but never carry.
- R9: Op 10 rotates left circular and op 11 rotates right circular. In both, the bit shifted out goes to cy_o and to the vacated bit. Op 12 (left) and op 13 (right) rotate through carry: cy_i enters the vacated bit and the bit shifted out goes to cy_o. Only carry is written.
- R10: Op 14 returns ~acc_i and writes no flag. Op 15 sets carry and op 16 inverts cy_i. Both return acc_i and write only carry.
- R11: Op 17 (decimal adjust) adds 0x06 when ac_i is set or the low nibble exceeds 9. It adds 0x60 when cy_i is set, when the high nibble exceeds 9, or when the high nibble is at least 9 and the low nibble exceeds 9. Carry becomes cy_i OR that second condition. The other flags follow the add rules, and all five are written.
- R12: Flag bit order is {S, Z, AC, P, CY}, from bit 4 down to bit 0, in both we_o and flags_q_o. On a clock edge with flag_we_i high, each flag whose we_o bit is set loads its next value, and every other flag holds. With flag_we_i low, nothing changes. Reset clears all flags.
- R13: Op codes 18 to 31 return acc_i and write no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current half-carry flag |
| flag_we_i | input | 1 | Flag file update strobe |
| res_o | output | 8 | Result byte |
| s_o | output | 1 | Next sign flag |
| z_o | output | 1 | Next zero flag |
| p_o | output | 1 | Next parity flag |
| ac_o | output | 1 | Next half-carry flag |
| cy_o | output | 1 | Next carry flag |
| we_o | output | 5 | Per-flag write mask {S,Z,AC,P,CY} |
| flags_q_o | output | 5 | Registered flags {S,Z,AC,P,CY} |

## Verification
The bench aims at the half-carry lookups with operands that place every combination of bit-3 values at the table index. A design that used the true nibble carry would disagree in the entries where the raw bit 3 differs from the carry. Subtract with borrow is tested at 0x00 minus 0xFF with the borrow set, the one case where the 9-bit difference wraps to exactly 0x100; a design that compared against a negative value with the wrong width would miss that borrow. Decimal adjust is tested on 0x9A and 0x9B, where the high nibble is exactly 9; a design that omitted the combined condition would leave both the carry and the 0x60 correction off. Compare is tested with unequal inputs so that a design that wrote back the difference shows up on res_o.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW    = 8;
  localparam int NIB   = 4;
  localparam int NFLAG = 5;
  localparam int OPW   = 5;
  localparam int HC_BIT = NIB - 1;

  localparam int FL_CY = 0;
  localparam int FL_P  = 1;
  localparam int FL_AC = 2;
  localparam int FL_Z  = 3;
  localparam int FL_S  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
    OP_CMC = 5'd16, OP_DAA = 5'd17
  } alu_op_e;

  // half-carry lookup, index {acc[3], operand[3], raw[3]}
  function automatic logic hc_add(input logic [2:0] idx);
    logic [7:0] tbl;
    tbl = 8'b1101_0100;
    return tbl[idx];
  endfunction

  function automatic logic hc_sub(input logic [2:0] idx);
    logic [7:0] tbl;
    tbl = 8'b1000_1110;
    return ~tbl[idx];
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            cy_i,
  input  logic            ac_i,
  output logic [DW-1:0]   res_o,
  output logic [DW-1:0]   flag_src_o,
  output logic            cy_o,
  output logic            ac_o
);
  localparam logic [NIB-1:0] DEC_MAX = NIB'(9);
  localparam logic [DW-1:0]  ADJ_LO  = DW'(8'h06);
  localparam logic [DW-1:0]  ADJ_HI  = DW'(8'h60);

  logic            sub_sel, use_cin, cin;
  logic            lo_adj, hi_adj;
  logic [NIB-1:0]  lo_n, hi_n;
  logic [DW-1:0]   b_eff;
  logic [DW:0]     raw;
  logic [2:0]      idx;

  assign lo_n    = a_i[NIB-1:0];
  assign hi_n    = a_i[DW-1:NIB];
  assign sub_sel = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
  assign use_cin = (op_i == OP_ADC) || (op_i == OP_SBB);
  assign cin     = use_cin & cy_i;

  assign lo_adj = ac_i | (lo_n > DEC_MAX);
  assign hi_adj = cy_i | (hi_n > DEC_MAX) | ((hi_n >= DEC_MAX) & (lo_n > DEC_MAX));

  always_comb begin
    if (op_i == OP_DAA) b_eff = (lo_adj ? ADJ_LO : '0) | (hi_adj ? ADJ_HI : '0);
    else                b_eff = b_i;
  end

  always_comb begin
    if (sub_sel) raw = {1'b0, a_i} - {1'b0, b_eff} - {{DW{1'b0}}, cin};
    else         raw = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
  end

  assign idx        = {a_i[HC_BIT], b_eff[HC_BIT], raw[HC_BIT]};
  assign ac_o       = sub_sel ? hc_sub(idx) : hc_add(idx);
  assign cy_o       = (op_i == OP_DAA) ? (cy_i | hi_adj) : raw[DW];
  assign flag_src_o = raw[DW-1:0];
  assign res_o      = (op_i == OP_CMP) ? a_i : raw[DW-1:0];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            cy_i,
  output logic [DW-1:0]   res_o,
  output logic            cy_o,
  output logic            ac_o
);
  localparam logic [NIB-1:0] NIB_ALL = '1;

  logic [DW-1:0] inc_v, dec_v;
  assign inc_v = a_i + DW'(1);
  assign dec_v = a_i - DW'(1);

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    ac_o  = 1'b0;
    unique case (op_i)
      OP_AND: begin res_o = a_i & b_i; ac_o = a_i[HC_BIT] | b_i[HC_BIT]; cy_o = 1'b0; end
      OP_OR:  begin res_o = a_i | b_i; cy_o = 1'b0; end
      OP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; end
      OP_INC: begin res_o = inc_v; ac_o = (inc_v[NIB-1:0] == '0); end
      OP_DEC: begin res_o = dec_v; ac_o = (dec_v[NIB-1:0] != NIB_ALL); end
      OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0]; end
      OP_RAL: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0]; end
      OP_CMA: res_o = ~a_i;
      OP_STC: cy_o = 1'b1;
      OP_CMC: cy_o = ~cy_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_we_dec.sv
module alu8_we_dec
  import alu8_pkg::*;
(
  input  alu_op_e           op_i,
  output logic [NFLAG-1:0]  we_o
);
  localparam logic [NFLAG-1:0] WE_ALL  = '1;
  localparam logic [NFLAG-1:0] WE_CY   = NFLAG'(1) << FL_CY;
  localparam logic [NFLAG-1:0] WE_NOCY = WE_ALL & ~WE_CY;

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP,
      OP_AND, OP_OR,  OP_XOR, OP_DAA:          we_o = WE_ALL;
      OP_INC, OP_DEC:                          we_o = WE_NOCY;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR,
      OP_STC, OP_CMC:                          we_o = WE_CY;
      default:                                 we_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [NFLAG-1:0]  we_i,
  input  logic [NFLAG-1:0]  nxt_i,
  output logic [NFLAG-1:0]  q_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q_o[g] <= 1'b0;
      else if (strobe_i && we_i[g]) q_o[g] <= nxt_i[g];
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPW-1:0]    op_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     opnd_i,
  input  logic              cy_i,
  input  logic              ac_i,
  input  logic              flag_we_i,
  output logic [DW-1:0]     res_o,
  output logic              s_o,
  output logic              z_o,
  output logic              p_o,
  output logic              ac_o,
  output logic              cy_o,
  output logic [NFLAG-1:0]  we_o,
  output logic [NFLAG-1:0]  flags_q_o
);
  alu_op_e       op;
  logic          is_arith;
  logic [DW-1:0] ar_res, ar_src, lg_res, src;
  logic          ar_cy, ar_ac, lg_cy, lg_ac;
  logic [NFLAG-1:0] nxt;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
                    (op == OP_SBB) || (op == OP_CMP) || (op == OP_DAA);

  alu8_arith u_arith (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(cy_i), .ac_i(ac_i),
    .res_o(ar_res), .flag_src_o(ar_src), .cy_o(ar_cy), .ac_o(ar_ac)
  );

  alu8_logic u_logic (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(cy_i),
    .res_o(lg_res), .cy_o(lg_cy), .ac_o(lg_ac)
  );

  alu8_we_dec u_we (.op_i(op), .we_o(we_o));

  assign res_o = is_arith ? ar_res : lg_res;
  assign src   = is_arith ? ar_src : lg_res;
  assign s_o   = src[DW-1];
  assign z_o   = (src == '0);
  assign p_o   = ~^src;
  assign ac_o  = is_arith ? ar_ac : lg_ac;
  assign cy_o  = is_arith ? ar_cy : lg_cy;

  always_comb begin
    nxt        = '0;
    nxt[FL_CY] = cy_o;
    nxt[FL_P]  = p_o;
    nxt[FL_AC] = ac_o;
    nxt[FL_Z]  = z_o;
    nxt[FL_S]  = s_o;
  end

  alu8_flagreg u_freg (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(flag_we_i),
    .we_i(we_o), .nxt_i(nxt), .q_o(flags_q_o)
  );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic       cy_i,
  input logic       flag_we_i,
  input logic [7:0] res_o,
  input logic       s_o,
  input logic       z_o,
  input logic       p_o,
  input logic       ac_o,
  input logic       cy_o,
  input logic [4:0] we_o,
  input logic [4:0] flags_q_o
);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_q_o));
  assert_cy_load_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && we_o[0]) |=> flags_q_o[0] == $past(cy_o));
  assert_cy_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !we_o[0]) |=> flags_q_o[0] == $past(flags_q_o[0]));
  assert_cmp_acc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd4) |-> (res_o == acc_i && we_o == 5'h1F));
  assert_cma_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd14) |-> (res_o == ~acc_i && we_o == 5'h00));
  assert_cmc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd16) |-> (cy_o == !cy_i && we_o == 5'h01));
  assert_incdec_cy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd8 || op_i == 5'd9) |-> !we_o[0]);
  assert_rot_only_cy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 5'd10 && op_i <= 5'd13) |-> we_o == 5'h01);
  assert_logic_cy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 5'd5 && op_i <= 5'd7) |-> (!cy_o && p_o == ~^res_o));
  assert_or_ac_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd6) |-> (!ac_o && res_o == (acc_i | opnd_i)));
  assert_add_sz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd0) |-> (z_o == (res_o == 8'h00) && s_o == res_o[7]));
  assert_undef_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 5'd18) |-> (we_o == 5'h00 && res_o == acc_i));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
  .cy_i(cy_i), .flag_we_i(flag_we_i), .res_o(res_o), .s_o(s_o), .z_o(z_o),
  .p_o(p_o), .ac_o(ac_o), .cy_o(cy_o), .we_o(we_o), .flags_q_o(flags_q_o)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic       cy_i = 1'b0, ac_i = 1'b0, flag_we_i = 1'b0;
  logic [7:0] res_o;
  logic       s_o, z_o, p_o, ac_o, cy_o;
  logic [4:0] we_o, flags_q_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [4:0] exp_q = '0;

  always #5 clk_i = ~clk_i;

  alu8_flags u_dut (.*);

  function automatic string req_of(input int op);
    case (op)
      0, 1: return "R1/R2/R6";
      2, 3: return "R3/R4/R6";
      4: return "R5";
      5, 6, 7: return "R7";
      8, 9: return "R8";
      10, 11, 12, 13: return "R9";
      14, 15, 16: return "R10";
      17: return "R11";
      default: return "R13";
    endcase
  endfunction

  function automatic logic par_even(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return (c % 2) == 0;
  endfunction

  // flag order {S,Z,AC,P,CY}
  task automatic ref_alu(input int op, input int a, input int b, input bit cy, input bit ac,
                         output logic [7:0] r, output logic [4:0] f, output logic [4:0] we);
    int t, idx, add;
    bit fcy, fac, lo, hi;
    logic [7:0] src;
    fcy = cy; fac = 0; r = a[7:0]; we = 5'h00;
    case (op)
      0, 1: begin
        t = a + b + ((op == 1) ? int'(cy) : 0);
        r = t[7:0]; src = r; fcy = t > 255;
        idx = (((a >> 3) & 1) << 2) | (((b >> 3) & 1) << 1) | ((t >> 3) & 1);
        fac = (idx == 2 || idx == 4 || idx == 6 || idx == 7); we = 5'h1F;
      end
      2, 3, 4: begin
        t = a - b - ((op == 3) ? int'(cy) : 0);
        src = t[7:0]; fcy = t < 0;
        idx = (((a >> 3) & 1) << 2) | (((b >> 3) & 1) << 1) | ((t >> 3) & 1);
        fac = !(idx == 1 || idx == 2 || idx == 3 || idx == 7); we = 5'h1F;
        r = (op == 4) ? a[7:0] : t[7:0];
      end
      5: begin r = a[7:0] & b[7:0]; fac = a[3] | b[3]; fcy = 0; we = 5'h1F; end
      6: begin r = a[7:0] | b[7:0]; fcy = 0; we = 5'h1F; end
      7: begin r = a[7:0] ^ b[7:0]; fcy = 0; we = 5'h1F; end
      8: begin r = 8'(a + 1); fac = (r % 16) == 0; we = 5'h1E; end
      9: begin r = 8'(a - 1); fac = (r % 16) != 15; we = 5'h1E; end
      10: begin r = 8'((a * 2) % 256 + a / 128); fcy = a >= 128; we = 5'h01; end
      11: begin r = 8'(a / 2 + (a % 2) * 128); fcy = a % 2; we = 5'h01; end
      12: begin r = 8'((a * 2) % 256 + int'(cy)); fcy = a >= 128; we = 5'h01; end
      13: begin r = 8'(a / 2 + int'(cy) * 128); fcy = a % 2; we = 5'h01; end
      14: r = 8'(255 - a);
      15: begin fcy = 1; we = 5'h01; end
      16: begin fcy = !cy; we = 5'h01; end
      17: begin
        lo = ac || (a % 16) > 9;
        hi = cy || (a / 16) > 9 || ((a / 16) >= 9 && (a % 16) > 9);
        add = (lo ? 6 : 0) + (hi ? 96 : 0);
        t = a + add; r = t[7:0];
        idx = (((a >> 3) & 1) << 2) | (((add >> 3) & 1) << 1) | ((t >> 3) & 1);
        fac = (idx == 2 || idx == 4 || idx == 6 || idx == 7);
        fcy = cy | hi; we = 5'h1F;
      end
      default: ;
    endcase
    if (op != 4) src = r;
    f = {src[7], src == 8'h00, fac, par_even(src), fcy};
  endtask

  task automatic check_comb;
    logic [7:0] r; logic [4:0] f, we, df;
    ref_alu(int'(op_i), int'(acc_i), int'(opnd_i), cy_i, ac_i, r, f, we);
    df = {s_o, z_o, ac_o, p_o, cy_o};
    n_chk++;
    if (r !== res_o || we !== we_o || (f & we) !== (df & we)) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h cy=%b ac=%b: res=%h we=%b fl=%b expected res=%h we=%b fl=%b",
               req_of(int'(op_i)), op_i, acc_i, opnd_i, cy_i, ac_i,
               res_o, we_o, df & we, r, we, f & we);
    end else if (flag_we_i) begin
      exp_q = (exp_q & ~we) | (f & we);
    end
  endtask

  task automatic check_q(input string tag);
    n_chk++;
    if (flags_q_o !== exp_q) begin
      n_fail++;
      $display("FAIL %s flag file: got %b expected %b", tag, flags_q_o, exp_q);
    end
  endtask

  task automatic apply(input int op, input int a, input int b, input bit cy, input bit ac, input bit we);
    @(negedge clk_i);
    op_i = 5'(op); acc_i = 8'(a); opnd_i = 8'(b); cy_i = cy; ac_i = ac; flag_we_i = we;
    #1 check_comb();
    @(posedge clk_i); #1;
    check_q("R12");
  endtask

  task automatic expect_val(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1 check_q("R12 reset");
    @(negedge clk_i) rst_ni = 1'b1;

    // directed corners
    apply(0, 8'h0F, 8'h01, 0, 0, 1);   // R2 idx 4
    apply(0, 8'h08, 8'h08, 0, 0, 1);   // R2 idx 6
    apply(1, 8'hFF, 8'h00, 1, 0, 1);   // R1 wrap to zero
    apply(3, 8'h00, 8'hFF, 1, 0, 1);   // R3 borrow at 0x100
    apply(2, 8'h10, 8'h01, 0, 0, 1);   // R4
    apply(4, 8'h20, 8'h30, 0, 0, 1);   // R5
    apply(5, 8'h08, 8'h00, 1, 0, 1);   // R7
    apply(8, 8'h0F, 8'h00, 1, 0, 1);   // R8
    apply(9, 8'h10, 8'h00, 1, 0, 1);   // R8
    apply(12, 8'h80, 8'h00, 1, 0, 1);  // R9
    apply(13, 8'h01, 8'h00, 0, 0, 1);  // R9
    apply(14, 8'h5A, 8'h00, 1, 1, 1);  // R10
    apply(15, 8'h00, 8'h00, 0, 0, 1);  // R10
    apply(17, 8'h9B, 8'h00, 0, 0, 1);  // R11
    expect_val("R11 daa 9B", res_o, 8'h01);
    apply(17, 8'h9A, 8'h00, 0, 0, 1);  // R11
    expect_val("R11 daa 9A", res_o, 8'h00);
    apply(20, 8'h33, 8'h44, 1, 1, 1);  // R13
    apply(0, 8'hFF, 8'hFF, 0, 0, 0);   // R12 strobe low, flags hold

    for (int i = 0; i < 20000; i++) begin
      int op;
      op = ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 18);
      apply(op, int'($urandom % 256), int'($urandom % 256),
            1'($urandom), 1'($urandom), ($urandom % 4) != 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule